// File: doc/BRIEF.md
# NAND Command Sequencer

This block sits between a host register bus and an 8-bit NAND flash device. The host writes register offsets to queue command, address, data-write and read-request entries into a four-deep write buffer. A pin engine drains that buffer one entry at a time. For each entry it drives chip enable, the latch strobes, the write or read strobe and the data bus. The read and write strobe low times come from a control register.

A read is a two-step transaction. A write of any value to the read-request offset queues one read strobe. The host waits for the sticky read-ready interrupt flag, takes the byte from the read-data offset and acknowledges the flag. The block also streams a whole ECC chunk of 256 or 512 bytes in page mode. A page read issues one read strobe per byte and presents each byte on a stream output. A page write counts plain data cycles until the chunk is complete. A reset offset clears the transfer counters and raises a strobe that clears the ECC accumulators outside this block.

Top module: `nfs_sequencer`

## Requirements
- R1: After reset the status word reads 0x11 (device ready, buffer empty), the interrupt-status and mask words are 0, `irq` is low, CE#, WE# and RE# are high, CLE, ALE and the data-bus enable are low.
- R2: Writing offset 4 (command) produces one WE# pulse with CE# low, CLE high, ALE low, and the low byte of the written value driven on the data bus.
- R3: Writing offset 5 (address) produces one WE# pulse with ALE high and CLE low, carrying the written byte. CLE and ALE are never high together.
- R4: Writing offset 6 (data write) produces one WE# pulse with CLE and ALE both low, carrying the written byte.
- R5: Writing any value to offset 7 (read request) produces one RE# pulse during which the data bus is not driven. The byte on the bus at the end of the pulse appears at offset 8, and interrupt-status bit 3 (read ready) is set.
- R6: Control word (offset 0): bit 0 page size (1 = 512 bytes, 0 = 256), bit 1 bus width, bits 5:2 read delay, bits 9:6 write delay. RE# is low for max(read delay,1) cycles and WE# for max(write delay,1) cycles.
- R7: The write buffer keeps four entries in first-in first-out order. Status bit 1 shows it is full and status bit 4 shows it is empty. A queued write while it is full is dropped and sets interrupt-status bit 1 (overflow). Interrupt-status bit 2 is set when the buffer goes from full to not full.
- R8: Writing a 1 to an interrupt-status bit (offset 2) clears it. Writing 0 leaves the bit as it was.
- R9: `irq` is high exactly when some interrupt-status bit is set whose bit in the mask word (offset 3) is also set.
- R10: Status bit 0 follows R/B# through a two-stage synchronizer. A low-to-high change of the synchronized value sets interrupt-status bit 0 (not busy).
- R11: Writing bit 0 of offset 9 starts a page read. Status bit 3 is high until one chunk of RE# cycles has completed, and every byte is presented on `rd_stream_data` with a one-cycle `rd_stream_valid`. Page-read bytes do not set read ready.
- R12: Writing bit 1 of offset 9 (with bit 0 clear) starts a page write. Status bit 2 is high until one chunk of data-write cycles has completed, and then interrupt-status bit 4 (page write done) is set.
- R13: Writing bit 0 of offset 10 makes that bit read 1 and `ecc_clr` high for RST_CYCLES cycles, after which both return to 0. The write also ends any pending page transfer and clears its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 2*DLY_W+2 | Register write data |
| host_rdata | output | 2*DLY_W+2 | Register read data, combinational on host_addr |
| irq | output | 1 | Masked interrupt request |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy from device, high when ready |
| rd_stream_valid | output | 1 | Page-read byte valid |
| rd_stream_data | output | 8 | Page-read byte |
| ecc_clr | output | 1 | ECC accumulator clear strobe |

## Verification
The hardest situation to reach from the ports is a full write buffer, which the overflow and full-to-not-full edge flags both depend on. The engine normally drains an entry within a few cycles, so the bench first programs the longest write strobe. It then issues six command writes on consecutive cycles. One entry goes to the engine at once, four fill the buffer and the sixth is dropped. The drained WE# log must then hold exactly five bytes in order. Page reads at the 512-byte size are checked against a device model that advances its byte on every RE# rise. Page writes are checked one byte short of the chunk and then at the full chunk.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WDATA = 2'd2,
        OP_RDREQ = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] data;
    } wb_entry_t;

    typedef struct packed {
        wb_entry_t ent;
        logic      from_page;
    } pin_op_t;

    localparam logic [3:0] REG_CTRL   = 4'd0;
    localparam logic [3:0] REG_STATUS = 4'd1;
    localparam logic [3:0] REG_IRQST  = 4'd2;
    localparam logic [3:0] REG_MASK   = 4'd3;
    localparam logic [3:0] REG_CMD    = 4'd4;
    localparam logic [3:0] REG_ADDR   = 4'd5;
    localparam logic [3:0] REG_DWR    = 4'd6;
    localparam logic [3:0] REG_RDREQ  = 4'd7;
    localparam logic [3:0] REG_RDATA  = 4'd8;
    localparam logic [3:0] REG_PAGE   = 4'd9;
    localparam logic [3:0] REG_RESET  = 4'd10;

    localparam int IRQ_W       = 5;
    localparam int IRQ_NOTBUSY = 0;
    localparam int IRQ_OVF     = 1;
    localparam int IRQ_EDGE    = 2;
    localparam int IRQ_RDRDY   = 3;
    localparam int IRQ_WRDONE  = 4;

endpackage

// File: rtl/nfs_wbuf.sv
module nfs_wbuf
    import nfs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wb_entry_t din,
    input  logic      pop,
    output wb_entry_t head,
    output logic      full,
    output logic      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        wb_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } wbuf_state_t;

    wbuf_state_t r_q, r_d;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        r_d = r_q;
        if (push) begin
            r_d.mem[r_q.wp] = din;
            r_d.wp          = wrap_inc(r_q.wp);
        end
        if (pop) begin
            r_d.rp = wrap_inc(r_q.rp);
        end
        case ({push, pop})
            2'b10:   r_d.cnt = r_q.cnt + CW'(1);
            2'b01:   r_d.cnt = r_q.cnt - CW'(1);
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign head  = r_q.mem[r_q.rp];
    assign full  = (r_q.cnt == CW'(DEPTH));
    assign empty = (r_q.cnt == '0);

endmodule

// File: rtl/nfs_pins.sv
module nfs_pins
    import nfs_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  pin_op_t          op,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic [7:0]       dq_in,
    output logic             idle,
    output logic             done,
    output pin_op_t          done_op,
    output logic [7:0]       cap_data,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       dq_out,
    output logic             dq_oe
);
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_SETUP  = 2'd1,
        PS_STROBE = 2'd2,
        PS_HOLD   = 2'd3
    } pin_state_e;

    typedef struct packed {
        pin_state_e       st;
        pin_op_t          op;
        logic [DLY_W-1:0] cnt;
        logic [7:0]       cap;
    } pins_state_t;

    pins_state_t r_q, r_d;
    logic [DLY_W-1:0] dly_sel;
    logic             is_read;

    assign is_read = (r_q.op.ent.kind == OP_RDREQ);
    assign dly_sel = is_read ? rd_dly : wr_dly;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            PS_IDLE: begin
                if (start) begin
                    r_d.op = op;
                    r_d.st = PS_SETUP;
                end
            end
            PS_SETUP: begin
                r_d.cnt = (dly_sel == '0) ? '0 : dly_sel - DLY_W'(1);
                r_d.st  = PS_STROBE;
            end
            PS_STROBE: begin
                if (r_q.cnt == '0) begin
                    r_d.st = PS_HOLD;
                    if (is_read) r_d.cap = dq_in;
                end else begin
                    r_d.cnt = r_q.cnt - DLY_W'(1);
                end
            end
            PS_HOLD: r_d.st = PS_IDLE;
            default: r_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign idle     = (r_q.st == PS_IDLE);
    assign done     = (r_q.st == PS_HOLD);
    assign done_op  = r_q.op;
    assign cap_data = r_q.cap;
    assign ce_n     = idle;
    assign cle      = !idle && (r_q.op.ent.kind == OP_CMD);
    assign ale      = !idle && (r_q.op.ent.kind == OP_ADDR);
    assign we_n     = !((r_q.st == PS_STROBE) && !is_read);
    assign re_n     = !((r_q.st == PS_STROBE) && is_read);
    assign dq_out   = r_q.op.ent.data;
    assign dq_oe    = !idle && !is_read;

endmodule

// File: rtl/nfs_sequencer.sv
module nfs_sequencer
    import nfs_pkg::*;
#(
    parameter int WB_DEPTH    = 4,
    parameter int DLY_W       = 4,
    parameter int RST_CYCLES  = 4,
    parameter int SMALL_CHUNK = 256,
    parameter int LARGE_CHUNK = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [3:0]           host_addr,
    input  logic [2*DLY_W+1:0]   host_wdata,
    output logic [2*DLY_W+1:0]   host_rdata,
    output logic                 irq,
    output logic                 nand_ce_n,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic [7:0]           nand_dq_out,
    output logic                 nand_dq_oe,
    input  logic [7:0]           nand_dq_in,
    input  logic                 nand_rb,
    output logic                 rd_stream_valid,
    output logic [7:0]           rd_stream_data,
    output logic                 ecc_clr
);
    localparam int CTRL_W = 2 * DLY_W + 2;
    localparam int PCW    = $clog2(LARGE_CHUNK + 1);
    localparam int RCW    = $clog2(RST_CYCLES + 1);
    localparam int RD_LSB = 2;
    localparam int WR_LSB = 2 + DLY_W;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [IRQ_W-1:0]  irq;
        logic [IRQ_W-1:0]  mask;
        logic [7:0]        rd_byte;
        logic              rd_pend;
        logic              wr_pend;
        logic [PCW-1:0]    pcnt;
        logic [RCW-1:0]    rcnt;
        logic [2:0]        rb_sync;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{
        ctrl: '0, irq: '0, mask: '0, rd_byte: '0, rd_pend: 1'b0,
        wr_pend: 1'b0, pcnt: '0, rcnt: '0, rb_sync: 3'b111
    };

    seq_state_t r_q, r_d;

    wb_entry_t wb_in, wb_head;
    logic      wb_push, wb_pop, wb_full, wb_empty;
    logic      is_queue_wr;
    logic      eng_idle, eng_start, eng_done;
    pin_op_t   eng_op, eng_done_op;
    logic [7:0] eng_cap;
    logic      resetting;
    logic [PCW-1:0] chunk_m1;
    logic [4:0] status;
    logic       wbuf_full;
    logic       irq_ovf_flag;

    assign wbuf_full    = wb_full;
    assign irq_ovf_flag = r_q.irq[IRQ_OVF];
    assign resetting    = (r_q.rcnt != '0);
    assign chunk_m1     = r_q.ctrl[0] ? PCW'(LARGE_CHUNK - 1) : PCW'(SMALL_CHUNK - 1);
    assign status       = {wb_empty, r_q.rd_pend, r_q.wr_pend, wb_full, r_q.rb_sync[1]};

    // host writes that enter the write buffer
    always_comb begin
        is_queue_wr = host_wr && ((host_addr == REG_CMD) || (host_addr == REG_ADDR) ||
                                  (host_addr == REG_DWR) || (host_addr == REG_RDREQ));
        wb_in.data = host_wdata[7:0];
        unique case (host_addr)
            REG_CMD:   wb_in.kind = OP_CMD;
            REG_ADDR:  wb_in.kind = OP_ADDR;
            REG_RDREQ: wb_in.kind = OP_RDREQ;
            default:   wb_in.kind = OP_WDATA;
        endcase
        wb_push = is_queue_wr && !wb_full;
    end

    // engine dispatch: buffer first, then page-read strobes
    always_comb begin
        eng_start        = 1'b0;
        wb_pop           = 1'b0;
        eng_op.ent       = wb_head;
        eng_op.from_page = 1'b0;
        if (eng_idle && !resetting) begin
            if (!wb_empty) begin
                eng_start = 1'b1;
                wb_pop    = 1'b1;
            end else if (r_q.rd_pend) begin
                eng_start        = 1'b1;
                eng_op.ent.kind  = OP_RDREQ;
                eng_op.ent.data  = 8'h00;
                eng_op.from_page = 1'b1;
            end
        end
    end

    always_comb begin
        logic [IRQ_W-1:0] set_ev;
        logic [IRQ_W-1:0] clr_ev;
        r_d    = r_q;
        set_ev = '0;
        clr_ev = '0;

        r_d.rb_sync = {r_q.rb_sync[1:0], nand_rb};
        set_ev[IRQ_NOTBUSY] = r_q.rb_sync[1] && !r_q.rb_sync[2];
        set_ev[IRQ_OVF]     = is_queue_wr && wb_full;
        set_ev[IRQ_EDGE]    = wb_full && wb_pop;

        if (resetting) r_d.rcnt = r_q.rcnt - RCW'(1);

        if (eng_done) begin
            if (eng_done_op.from_page) begin
                r_d.pcnt = r_q.pcnt + PCW'(1);
                if (r_q.pcnt == chunk_m1) begin
                    r_d.rd_pend = 1'b0;
                    r_d.pcnt    = '0;
                end
            end else if (eng_done_op.ent.kind == OP_RDREQ) begin
                r_d.rd_byte       = eng_cap;
                set_ev[IRQ_RDRDY] = 1'b1;
            end else if ((eng_done_op.ent.kind == OP_WDATA) && r_q.wr_pend) begin
                r_d.pcnt = r_q.pcnt + PCW'(1);
                if (r_q.pcnt == chunk_m1) begin
                    r_d.wr_pend        = 1'b0;
                    r_d.pcnt           = '0;
                    set_ev[IRQ_WRDONE] = 1'b1;
                end
            end
        end

        if (host_wr) begin
            unique case (host_addr)
                REG_CTRL:  r_d.ctrl = host_wdata;
                REG_IRQST: clr_ev   = host_wdata[IRQ_W-1:0];
                REG_MASK:  r_d.mask = host_wdata[IRQ_W-1:0];
                REG_PAGE: begin
                    if (!r_q.rd_pend && !r_q.wr_pend && !resetting) begin
                        if (host_wdata[0]) begin
                            r_d.rd_pend = 1'b1;
                            r_d.pcnt    = '0;
                        end else if (host_wdata[1]) begin
                            r_d.wr_pend = 1'b1;
                            r_d.pcnt    = '0;
                        end
                    end
                end
                REG_RESET: if (host_wdata[0]) r_d.rcnt = RCW'(RST_CYCLES);
                default: ;
            endcase
        end

        if (resetting || (host_wr && (host_addr == REG_RESET) && host_wdata[0])) begin
            r_d.rd_pend = 1'b0;
            r_d.wr_pend = 1'b0;
            r_d.pcnt    = '0;
        end

        r_d.irq = (r_q.irq & ~clr_ev) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RESET;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (host_addr)
            REG_CTRL:   host_rdata = r_q.ctrl;
            REG_STATUS: host_rdata = CTRL_W'(status);
            REG_IRQST:  host_rdata = CTRL_W'(r_q.irq);
            REG_MASK:   host_rdata = CTRL_W'(r_q.mask);
            REG_RDATA:  host_rdata = CTRL_W'(r_q.rd_byte);
            REG_RESET:  host_rdata = CTRL_W'(resetting);
            default:    host_rdata = '0;
        endcase
    end

    nfs_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wb_push),
        .din   (wb_in),
        .pop   (wb_pop),
        .head  (wb_head),
        .full  (wb_full),
        .empty (wb_empty)
    );

    nfs_pins #(.DLY_W(DLY_W)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .op       (eng_op),
        .rd_dly   (r_q.ctrl[RD_LSB +: DLY_W]),
        .wr_dly   (r_q.ctrl[WR_LSB +: DLY_W]),
        .dq_in    (nand_dq_in),
        .idle     (eng_idle),
        .done     (eng_done),
        .done_op  (eng_done_op),
        .cap_data (eng_cap),
        .ce_n     (nand_ce_n),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_out   (nand_dq_out),
        .dq_oe    (nand_dq_oe)
    );

    assign irq             = |(r_q.irq & r_q.mask);
    assign rd_stream_valid = eng_done && eng_done_op.from_page;
    assign rd_stream_data  = eng_cap;
    assign ecc_clr         = resetting;

endmodule

// File: rtl/nfs_sequencer_chk.sv
module nfs_sequencer_chk
    import nfs_pkg::*;
#(
    parameter int HW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic [3:0]    host_addr,
    input logic [HW-1:0] host_wdata,
    input logic          nand_ce_n,
    input logic          nand_cle,
    input logic          nand_ale,
    input logic          nand_we_n,
    input logic          nand_re_n,
    input logic          nand_dq_oe,
    input logic          wbuf_full,
    input logic          irq_ovf_flag,
    input logic          ecc_clr
);
    logic queue_wr;
    assign queue_wr = host_wr && ((host_addr == REG_CMD) || (host_addr == REG_ADDR) ||
                                  (host_addr == REG_DWR) || (host_addr == REG_RDREQ));

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    assert_ce_with_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_wr && wbuf_full) |=> irq_ovf_flag);

    assert_reset_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_addr == REG_RESET) && host_wdata[0]) |=> ecc_clr);

endmodule

bind nfs_sequencer nfs_sequencer_chk #(.HW(2*DLY_W+2)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .nand_ce_n    (nand_ce_n),
    .nand_cle     (nand_cle),
    .nand_ale     (nand_ale),
    .nand_we_n    (nand_we_n),
    .nand_re_n    (nand_re_n),
    .nand_dq_oe   (nand_dq_oe),
    .wbuf_full    (wbuf_full),
    .irq_ovf_flag (irq_ovf_flag),
    .ecc_clr      (ecc_clr)
);

// File: tb/nfs_sequencer_bench.sv
`timescale 1ns/1ps
module nfs_sequencer_bench;
    localparam int HW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [3:0]    host_addr = 4'd0;
    logic [HW-1:0] host_wdata = '0;
    logic [HW-1:0] host_rdata;
    logic          irq;
    logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]    nand_dq_out;
    logic [7:0]    nand_dq_in;
    logic          nand_rb = 1'b1;
    logic          rd_stream_valid;
    logic [7:0]    rd_stream_data;
    logic          ecc_clr;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nfs_sequencer u_nfs_sequencer (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
        .rd_stream_valid(rd_stream_valid), .rd_stream_data(rd_stream_data),
        .ecc_clr(ecc_clr)
    );

    // device model and pin monitor
    logic [7:0] pat = 8'h3C;
    logic [7:0] stream_exp = 8'h00;
    int  stream_cnt = 0, stream_bad = 0, bad_drive = 0;
    int  we_total = 0, re_total = 0, we_run = 0, re_run = 0;
    int  last_we_w = 0, last_re_w = 0;
    logic last_cle = 0, last_ale = 0, last_oe = 0;
    logic [7:0] last_byte = 0;
    logic [7:0] we_log [0:63];
    logic prev_we = 1'b1, prev_re = 1'b1;

    assign nand_dq_in = pat;

    always @(negedge clk) begin
        if (rd_stream_valid) begin
            if (rd_stream_data != stream_exp) stream_bad++;
            stream_exp = stream_exp + 8'd1;
            stream_cnt++;
        end
        if (!nand_re_n && nand_dq_oe) bad_drive++;
        if (!nand_we_n) begin
            we_run++;
            last_cle  = nand_cle;
            last_ale  = nand_ale;
            last_oe   = nand_dq_oe;
            last_byte = nand_dq_out;
        end else if (!prev_we) begin
            last_we_w = we_run;
            we_log[we_total % 64] = last_byte;
            we_total++;
            we_run = 0;
        end
        if (!nand_re_n) re_run++;
        else if (!prev_re) begin
            last_re_w = re_run;
            re_total++;
            re_run = 0;
            pat = pat + 8'd1;
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [HW-1:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(posedge clk);
        #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        host_addr = a;
        #1;
        v = int'(host_rdata);
    endtask

    function automatic logic [HW-1:0] ctrl_word(input bit ps, input int rdd, input int wrd);
        return {wrd[3:0], rdd[3:0], 1'b0, ps};
    endfunction

    task automatic wait_quiet();
        int s;
        for (int i = 0; i < 20000; i++) begin
            rd(4'd1, s);
            if (s[4] && !s[3] && nand_ce_n) return;
        end
    endtask

    task automatic t_reset();
        int v;
        rd(4'd1, v); check("R1", "status", v, 'h11);
        rd(4'd2, v); check("R1", "irq status", v, 0);
        rd(4'd3, v); check("R1", "mask", v, 0);
        check("R1", "irq", irq, 0);
        check("R1", "pins", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 'b111000);
    endtask

    task automatic t_cycles();
        wr(4'd0, ctrl_word(0, 0, 0));
        wr(4'd4, 10'h090); wait_quiet();
        check("R2", "cmd latch cle/ale/oe", {last_cle, last_ale, last_oe}, 'b101);
        check("R2", "cmd byte", last_byte, 'h90);
        check("R6", "min WE width", last_we_w, 1);
        wr(4'd5, 10'h012); wait_quiet();
        check("R3", "addr latch cle/ale", {last_cle, last_ale}, 'b01);
        check("R3", "addr byte", last_byte, 'h12);
        wr(4'd6, 10'h0A5); wait_quiet();
        check("R4", "data cle/ale/oe", {last_cle, last_ale, last_oe}, 'b001);
        check("R4", "data byte", last_byte, 'hA5);
    endtask

    task automatic t_strobe();
        int v;
        wr(4'd0, ctrl_word(0, 5, 3));
        wr(4'd4, 10'h0FF); wait_quiet();
        check("R6", "WE width", last_we_w, 3);
        wr(4'd7, 10'h000); wait_quiet();
        check("R6", "RE width", last_re_w, 5);
        wr(4'd2, 10'h01F);
        wr(4'd0, ctrl_word(0, 0, 0));
        wr(4'd7, 10'h000); wait_quiet();
        check("R6", "min RE width", last_re_w, 1);
        rd(4'd0, v); check("R6", "ctrl readback", v, ctrl_word(0, 0, 0));
        wr(4'd2, 10'h01F);
    endtask

    task automatic t_read();
        int v;
        logic [7:0] exp;
        exp = pat;
        wr(4'd7, 10'h3FF); wait_quiet();
        rd(4'd2, v); check("R5", "read ready", v & 8, 8);
        rd(4'd8, v); check("R5", "read byte", v, exp);
        check("R5", "bus driven during RE", bad_drive, 0);
        wr(4'd2, 10'h000);
        rd(4'd2, v); check("R8", "write 0 keeps bit", v & 8, 8);
        wr(4'd2, 10'h008);
        rd(4'd2, v); check("R8", "write 1 clears bit", v & 8, 0);
    endtask

    task automatic t_irq();
        wr(4'd7, 10'h000); wait_quiet();
        wr(4'd3, 10'h000); #1; check("R9", "irq mask none", irq, 0);
        wr(4'd3, 10'h008); #1; check("R9", "irq mask rdrdy", irq, 1);
        wr(4'd3, 10'h017); #1; check("R9", "irq other bits", irq, 0);
        wr(4'd2, 10'h01F);
        wr(4'd3, 10'h01F); #1; check("R9", "irq after clear", irq, 0);
        wr(4'd3, 10'h000);
    endtask

    task automatic t_fifo();
        int v, base;
        wr(4'd0, ctrl_word(0, 1, 15));
        base = we_total;
        for (int i = 0; i < 6; i++) wr(4'd4, 10'(8'hB0 + i));
        rd(4'd1, v); check("R7", "full bit", v & 2, 2);
        rd(4'd2, v); check("R7", "overflow flag", v & 2, 2);
        wait_quiet();
        check("R7", "accepted count", we_total - base, 5);
        for (int i = 0; i < 5; i++)
            check("R7", "fifo order", we_log[(base + i) % 64], 8'hB0 + i);
        rd(4'd2, v); check("R7", "edge flag", v & 4, 4);
        rd(4'd1, v); check("R7", "empty bit", v & 16, 16);
        wr(4'd2, 10'h01F);
        wr(4'd0, ctrl_word(0, 0, 0));
    endtask

    task automatic t_ready();
        int v;
        @(negedge clk) nand_rb = 1'b0;
        repeat (3) @(posedge clk);
        rd(4'd1, v); check("R10", "busy seen", v & 1, 0);
        rd(4'd2, v); check("R10", "no event while busy", v & 1, 0);
        @(negedge clk) nand_rb = 1'b1;
        repeat (4) @(posedge clk);
        rd(4'd1, v); check("R10", "ready seen", v & 1, 1);
        rd(4'd2, v); check("R10", "not-busy event", v & 1, 1);
        wr(4'd2, 10'h01F);
    endtask

    task automatic t_page_read();
        int v, base;
        wr(4'd0, ctrl_word(1, 1, 1));
        stream_exp = pat;
        stream_cnt = 0;
        stream_bad = 0;
        base = re_total;
        wr(4'd9, 10'h001);
        rd(4'd1, v); check("R11", "read pending", v & 8, 8);
        wait_quiet();
        check("R11", "stream count 512", stream_cnt, 512);
        check("R11", "stream data errors", stream_bad, 0);
        check("R11", "RE cycles", re_total - base, 512);
        rd(4'd2, v); check("R11", "no read ready", v & 8, 0);
    endtask

    task automatic t_page_write();
        int v, base;
        wr(4'd0, ctrl_word(0, 1, 1));
        base = we_total;
        wr(4'd9, 10'h002);
        rd(4'd1, v); check("R12", "write pending", v & 4, 4);
        for (int i = 0; i < 256; i++) begin
            for (int k = 0; k < 100; k++) begin
                rd(4'd1, v);
                if (!v[1]) break;
            end
            wr(4'd6, 10'(i & 255));
            if (i == 254) begin
                wait_quiet();
                rd(4'd1, v); check("R12", "pending before last", v & 4, 4);
                rd(4'd2, v); check("R12", "no done before last", v & 16, 0);
            end
        end
        wait_quiet();
        rd(4'd1, v); check("R12", "pending cleared", v & 4, 0);
        rd(4'd2, v); check("R12", "write done", v & 16, 16);
        check("R12", "WE cycles", we_total - base, 256);
        wr(4'd2, 10'h01F);
    endtask

    task automatic t_reset_reg();
        int v;
        wr(4'd9, 10'h002);
        rd(4'd1, v); check("R13", "pending set", v & 4, 4);
        wr(4'd10, 10'h001);
        #1;
        check("R13", "ecc_clr high", ecc_clr, 1);
        host_addr = 4'd10; #1;
        check("R13", "reset bit reads 1", host_rdata[0], 1);
        repeat (4) @(posedge clk);
        #1;
        check("R13", "reset bit self-clears", host_rdata[0], 0);
        check("R13", "ecc_clr low", ecc_clr, 0);
        rd(4'd1, v); check("R13", "pending cleared", v & 4, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_cycles();
        t_strobe();
        t_read();
        t_irq();
        t_fifo();
        t_ready();
        t_page_read();
        t_page_write();
        t_reset_reg();
        finish_run();
    end

endmodule